// File: doc/BRIEF.md
# PS/2 Serial Frame Receiver

This block listens to a PS/2 keyboard or mouse. The device drives both the bit clock and the data line, and the host never drives them, so both pins are plain inputs. The two lines are asynchronous to the system clock. Each one passes through a multi-flop synchronizer. The clock line is then debounced: a new level is accepted only after it has held for a programmable number of system cycles. The data line is sampled on each accepted falling edge of the device clock.

Each frame carries eleven bits. A start bit of 0 comes first, then eight data bits with the least significant bit first, then an odd-parity bit, then a stop bit of 1. When the eleventh bit arrives, the block checks the frame. A good frame gives the data byte and a one-cycle valid strobe. A frame with a bad start, parity or stop bit gives a one-cycle error strobe instead. If the device clock stays high for too long in the middle of a frame, the partial frame is dropped and the receiver waits again for a start bit. Both lines idle high.

Top module: `ps2_frame_rx`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the receiver goes to its idle state. `rx_valid` and `rx_err` are then 0 and `rx_byte` is 0x00.
- R2: A frame with start=0, odd parity over the data and parity bits, and stop=1 gives a single-cycle `rx_valid` pulse. At that cycle `rx_byte` holds the eight data bits, and the first data bit received is bit 0.
- R3: A frame whose data bits plus parity bit hold an even number of ones gives a single-cycle `rx_err` pulse and no `rx_valid`.
- R4: A frame whose eleventh bit is 0 gives a single-cycle `rx_err` pulse and no `rx_valid`.
- R5: A frame whose first bit is 1 gives a single-cycle `rx_err` pulse and no `rx_valid`.
- R6: A low pulse on `ps2_clk` shorter than `DEBOUNCE_CYCLES` system cycles is not counted as a clock edge. This holds both while idle and during the high phase of a frame.
- R7: Inside a frame, if the debounced device clock stays high for `TIMEOUT_CYCLES` cycles, the partial frame is dropped and no strobe is given. The next complete frame is then received correctly.
- R8: `rx_valid` and `rx_err` are never high in the same cycle, and `rx_byte` changes only in a cycle where one of them is high.
- R9: Frames sent back to back each give their own strobe, in the order they were sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ps2_clk | input | 1 | Device bit clock, asynchronous |
| ps2_data | input | 1 | Device serial data, asynchronous |
| rx_byte | output | 8 | Last completed frame's data byte |
| rx_valid | output | 1 | One-cycle strobe for a good frame |
| rx_err | output | 1 | One-cycle strobe for a bad frame |

## Verification
The bench aims at the three ways a frame can be bad: parity, stop and start. A receiver that skipped any one of these checks would raise `rx_valid` on a corrupt byte. Short low glitches are injected while idle and during a high phase of a frame. A design without debouncing would count an extra bit, shift the byte and report a framing error. A frame is abandoned after five bits and followed by a clean one. A receiver without a timeout would merge the two frames and report an error or a wrong byte. Data bytes with asymmetric bit patterns are used so that a reversed bit order shows up, and back-to-back frames expose a bit counter that does not rearm.

// File: rtl/ps2rx_pkg.sv
// Package: shared constants and helpers for the PS/2 frame receiver.
// Assumes the frame is assembled by shifting each new bit into the MSB,
// so after eleven shifts the start bit is at index 0.
package ps2rx_pkg;
    localparam int FRAME_BITS = 11;
    localparam int DATA_BITS  = 8;
    localparam int IDX_START  = 0;
    localparam int IDX_DATA   = 1;
    localparam int IDX_PARITY = IDX_DATA + DATA_BITS;
    localparam int IDX_STOP   = FRAME_BITS - 1;
    localparam int BITCNT_W   = $clog2(FRAME_BITS + 1);

    typedef enum logic [0:0] {RX_IDLE = 1'b0, RX_BUSY = 1'b1} rx_state_t;

    // Returns 1 when the data bits plus the parity bit hold an odd number of ones.
    function automatic logic odd_ok(input logic [DATA_BITS-1:0] d, input logic p);
        return ^{d, p};
    endfunction
endpackage

// File: rtl/ps2rx_sync.sv
// Module: multi-flop synchronizer for an asynchronous, idle-high line.
// Assumes STAGES >= 2. The reset value is 1, which matches the idle bus level.
module ps2rx_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                // Capture the raw asynchronous level.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b1;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                // Pass the level one stage further down the chain.
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[i] <= 1'b1;
                    else        chain[i] <= chain[i-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/ps2rx_debounce.sv
// Module: debounces the synchronized device clock and flags accepted falling edges.
// A new level is accepted once the input has differed from the current level
// for STABLE_CYCLES consecutive cycles. Assumes STABLE_CYCLES >= 1.
module ps2rx_debounce #(
    parameter int STABLE_CYCLES = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_in,
    output logic level_out,
    output logic fall
);
    localparam int CNT_W = $clog2(STABLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STABLE_CYCLES - 1);

    logic [CNT_W-1:0] cnt;
    logic             level_q;
    logic             level_prev;

    // Count how long the input has disagreed; commit the new level at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= '0;
            level_q <= 1'b1;
        end else if (level_in == level_q) begin
            cnt <= '0;
        end else if (cnt == CNT_LAST) begin
            cnt     <= '0;
            level_q <= level_in;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    // Remember the previous accepted level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) level_prev <= 1'b1;
        else        level_prev <= level_q;
    end

    assign level_out = level_q;
    assign fall      = level_prev & ~level_q;
endmodule

// File: rtl/ps2rx_frame.sv
// Module: assembles an 11-bit frame from the sampled data and checks it.
// Assumes `fall` is a one-cycle pulse per accepted falling clock edge, and that
// `clk_level` is the debounced device clock used for the mid-frame timeout.
module ps2rx_frame
    import ps2rx_pkg::*;
#(
    parameter int TIMEOUT_CYCLES = 25000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 fall,
    input  logic                 data_bit,
    input  logic                 clk_level,
    output logic [DATA_BITS-1:0] byte_out,
    output logic                 valid,
    output logic                 err,
    output logic                 active
);
    localparam int TO_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [TO_W-1:0]     TO_LAST  = TO_W'(TIMEOUT_CYCLES - 1);
    localparam logic [BITCNT_W-1:0] BIT_LAST = BITCNT_W'(FRAME_BITS - 1);

    rx_state_t               state;
    logic [FRAME_BITS-1:0]   shreg;
    logic [FRAME_BITS-1:0]   sh_next;
    logic [BITCNT_W-1:0]     bitcnt;
    logic [TO_W-1:0]         tcnt;
    logic                    last_bit;
    logic                    frame_good;
    logic                    timed_out;

    // Next shift value and the frame check on the completed frame.
    always_comb begin
        sh_next    = {data_bit, shreg[FRAME_BITS-1:1]};
        last_bit   = (state == RX_BUSY) && (bitcnt == BIT_LAST);
        frame_good = (sh_next[IDX_START] == 1'b0) &&
                     (sh_next[IDX_STOP] == 1'b1) &&
                     odd_ok(sh_next[IDX_PARITY-1:IDX_DATA], sh_next[IDX_PARITY]);
        timed_out  = (state == RX_BUSY) && clk_level && (tcnt == TO_LAST);
    end

    // Frame sequencing: start on the first edge, finish on the eleventh, drop on timeout.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RX_IDLE;
            shreg  <= '0;
            bitcnt <= '0;
        end else if (fall) begin
            shreg <= sh_next;
            if (state == RX_IDLE) begin
                state  <= RX_BUSY;
                bitcnt <= BITCNT_W'(1);
            end else if (last_bit) begin
                state  <= RX_IDLE;
                bitcnt <= '0;
            end else begin
                bitcnt <= bitcnt + 1'b1;
            end
        end else if (timed_out) begin
            state  <= RX_IDLE;
            bitcnt <= '0;
        end
    end

    // Count cycles of clock-high inside a frame; clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)                                tcnt <= '0;
        else if (state != RX_BUSY || !clk_level)   tcnt <= '0;
        else if (tcnt != TO_LAST)                  tcnt <= tcnt + 1'b1;
    end

    // Result registers: byte and a one-cycle strobe on frame completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            byte_out <= '0;
            valid    <= 1'b0;
            err      <= 1'b0;
        end else begin
            valid <= 1'b0;
            err   <= 1'b0;
            if (fall && last_bit) begin
                byte_out <= sh_next[IDX_PARITY-1:IDX_DATA];
                valid    <= frame_good;
                err      <= !frame_good;
            end
        end
    end

    assign active = (state == RX_BUSY);
endmodule

// File: rtl/ps2_frame_rx.sv
// Module: top of the PS/2 receive path: synchronizers, clock debouncer, frame engine.
// Assumes the device clock high and low phases are each longer than
// DEBOUNCE_CYCLES + SYNC_STAGES system cycles, and TIMEOUT_CYCLES is longer
// than the longest legal high phase.
module ps2_frame_rx
    import ps2rx_pkg::*;
#(
    parameter int SYNC_STAGES     = 2,
    parameter int DEBOUNCE_CYCLES = 250,
    parameter int TIMEOUT_CYCLES  = 25000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps2_clk,
    input  logic       ps2_data,
    output logic [7:0] rx_byte,
    output logic       rx_valid,
    output logic       rx_err
);
    logic clk_sync;
    logic data_sync;
    logic clk_level;
    logic clk_fall;
    logic frame_active;

    ps2rx_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
        .clk(clk), .rst_n(rst_n), .async_in(ps2_clk), .sync_out(clk_sync)
    );

    ps2rx_sync #(.STAGES(SYNC_STAGES)) u_sync_data (
        .clk(clk), .rst_n(rst_n), .async_in(ps2_data), .sync_out(data_sync)
    );

    ps2rx_debounce #(.STABLE_CYCLES(DEBOUNCE_CYCLES)) u_deb (
        .clk(clk), .rst_n(rst_n), .level_in(clk_sync),
        .level_out(clk_level), .fall(clk_fall)
    );

    ps2rx_frame #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_frame (
        .clk(clk), .rst_n(rst_n), .fall(clk_fall), .data_bit(data_sync),
        .clk_level(clk_level), .byte_out(rx_byte), .valid(rx_valid),
        .err(rx_err), .active(frame_active)
    );
endmodule

// File: rtl/ps2rx_checker.sv
// Module: property checker for ps2_frame_rx, attached with bind.
// Assumes it sees the top ports plus the debounced clock level and frame-busy flag.
module ps2rx_checker #(
    parameter int TIMEOUT_CYCLES = 25000
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] rx_byte,
    input logic       rx_valid,
    input logic       rx_err,
    input logic       clk_level,
    input logic       frame_active
);
    localparam int HW = $clog2(TIMEOUT_CYCLES + 2) + 1;
    logic [HW-1:0] hi_cnt;

    // Count consecutive clock-high cycles spent inside a frame.
    always_ff @(posedge clk) begin
        if (!rst_n)                         hi_cnt <= '0;
        else if (frame_active && clk_level) hi_cnt <= hi_cnt + 1'b1;
        else                                hi_cnt <= '0;
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!rx_valid && !rx_err && rx_byte == 8'h00));

    p_valid_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    p_err_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rx_err |=> !rx_err);

    p_timeout_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hi_cnt <= HW'(TIMEOUT_CYCLES));

    p_strobe_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_valid && rx_err));

    p_byte_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte) |-> (rx_valid || rx_err));
endmodule

bind ps2_frame_rx ps2rx_checker #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
    .clk(clk), .rst_n(rst_n), .rx_byte(rx_byte), .rx_valid(rx_valid),
    .rx_err(rx_err), .clk_level(clk_level), .frame_active(frame_active)
);

// File: tb/tb_ps2_frame_rx.sv
// Bench: directed scenarios, one task each, driving PS/2 frames at a scaled bit rate.
module tb_ps2_frame_rx;
    localparam int DEB  = 4;
    localparam int TOUT = 300;
    localparam int HALF = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ps2_clk = 1'b1;
    logic       ps2_data = 1'b1;
    logic [7:0] rx_byte;
    logic       rx_valid;
    logic       rx_err;

    int errors = 0;
    int checks = 0;
    int n_valid = 0;
    int n_err = 0;
    logic [7:0] last_byte = 8'h00;
    logic [7:0] first_byte = 8'h00;
    int cycles = 0;

    always #2 clk = ~clk;

    ps2_frame_rx #(.SYNC_STAGES(2), .DEBOUNCE_CYCLES(DEB), .TIMEOUT_CYCLES(TOUT)) dut (
        .clk(clk), .rst_n(rst_n), .ps2_clk(ps2_clk), .ps2_data(ps2_data),
        .rx_byte(rx_byte), .rx_valid(rx_valid), .rx_err(rx_err)
    );

    // Record strobes away from the active edge.
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (n_valid == 0) first_byte = rx_byte;
            n_valid++;
            last_byte = rx_byte;
        end
        if (rst_n && rx_err) n_err++;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    task automatic clear_counts;
        n_valid = 0;
        n_err   = 0;
    endtask

    // Send nbits of an 11-bit frame; optional glitch in the high phase before bit 4.
    task automatic send_bits(input logic [10:0] frame, input int nbits, input bit glitch);
        for (int b = 0; b < nbits; b++) begin
            ps2_data = frame[b];
            if (glitch && b == 4) begin
                wait_cyc(HALF / 2);
                ps2_clk = 1'b0;
                wait_cyc(2);
                ps2_clk = 1'b1;
                wait_cyc(HALF / 2 - 2);
            end else begin
                wait_cyc(HALF);
            end
            ps2_clk = 1'b0;
            wait_cyc(HALF);
            ps2_clk = 1'b1;
        end
        wait_cyc(HALF);
        ps2_data = 1'b1;
    endtask

    function automatic logic [10:0] mk(input logic [7:0] d, input bit bad_par,
                                       input logic st, input logic sp);
        logic p;
        p = ~(^d) ^ bad_par;
        return {sp, p, d, st};
    endfunction

    task automatic t_reset;
        rst_n = 1'b0;
        wait_cyc(3);
        @(negedge clk);
        chk("R1 rx_valid in reset", int'(rx_valid), 0);
        chk("R1 rx_err in reset", int'(rx_err), 0);
        chk("R1 rx_byte in reset", int'(rx_byte), 0);
        rst_n = 1'b1;
        wait_cyc(5);
    endtask

    task automatic t_good(input logic [7:0] d);
        clear_counts();
        send_bits(mk(d, 0, 1'b0, 1'b1), 11, 0);
        wait_cyc(20);
        chk("R2 valid count", n_valid, 1);
        chk("R2 err count", n_err, 0);
        chk("R2 byte LSB first", int'(last_byte), int'(d));
    endtask

    task automatic t_parity;
        clear_counts();
        send_bits(mk(8'h3C, 1, 1'b0, 1'b1), 11, 0);
        wait_cyc(20);
        chk("R3 err count", n_err, 1);
        chk("R3 valid count", n_valid, 0);
    endtask

    task automatic t_stop;
        clear_counts();
        send_bits(mk(8'hA1, 0, 1'b0, 1'b0), 11, 0);
        wait_cyc(20);
        chk("R4 err count", n_err, 1);
        chk("R4 valid count", n_valid, 0);
    endtask

    task automatic t_start;
        clear_counts();
        send_bits(mk(8'h5E, 0, 1'b1, 1'b1), 11, 0);
        wait_cyc(20);
        chk("R5 err count", n_err, 1);
        chk("R5 valid count", n_valid, 0);
    endtask

    task automatic t_glitch;
        clear_counts();
        ps2_clk = 1'b0;
        wait_cyc(2);
        ps2_clk = 1'b1;
        wait_cyc(HALF);
        send_bits(mk(8'hC5, 0, 1'b0, 1'b1), 11, 1);
        wait_cyc(20);
        chk("R6 valid count", n_valid, 1);
        chk("R6 err count", n_err, 0);
        chk("R6 byte", int'(last_byte), 8'hC5);
    endtask

    task automatic t_timeout;
        clear_counts();
        send_bits(mk(8'hFF, 0, 1'b0, 1'b1), 5, 0);
        wait_cyc(TOUT + 100);
        chk("R7 no strobe after partial frame", n_valid + n_err, 0);
        send_bits(mk(8'h92, 0, 1'b0, 1'b1), 11, 0);
        wait_cyc(20);
        chk("R7 valid count", n_valid, 1);
        chk("R7 err count", n_err, 0);
        chk("R7 byte", int'(last_byte), 8'h92);
    endtask

    task automatic t_b2b;
        clear_counts();
        send_bits(mk(8'h01, 0, 1'b0, 1'b1), 11, 0);
        send_bits(mk(8'h80, 0, 1'b0, 1'b1), 11, 0);
        wait_cyc(20);
        chk("R9 valid count", n_valid, 2);
        chk("R9 first byte", int'(first_byte), 8'h01);
        chk("R9 second byte", int'(last_byte), 8'h80);
        chk("R8 no err", n_err, 0);
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=200000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_good(8'h1B);
        t_good(8'hE4);
        t_parity();
        t_stop();
        t_start();
        t_glitch();
        t_timeout();
        t_b2b();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule